// File: doc/BRIEF.md
# Signed multiply-accumulate with add/subtract select

The block adds the product of two two's-complement operands to a signed addend, or subtracts it, and registers the result. X is `P_W` bits and Y is `Q_W` bits. The addend Z is `P_W+Q_W` bits. The result is one bit wider than Z, so no combination of operands can overflow it.

The product is never formed as a separate signed multiply. It is built as partial-product rows that feed one shared summation together with Z. The `SPLIT` parameter chooses how the rows are made:
- **Bit-level form (`SPLIT=0`).** The rows are:
  - the unsigned product of the two low parts;
  - the single AND of the two sign bits, placed at weight 2^(P_W+Q_W-2);
  - the low part of Y gated by the X sign, at weight 2^(P_W-1);
  - the low part of X gated by the Y sign, at weight 2^(Q_W-1).

  The last two rows carry negative weight.
- **Split form (`SPLIT=1`).** Each operand is cut into a signed top slice of `XH_W` (or `YH_W`) bits and an unsigned remainder. The four cross sub-products are the rows.

A row with negative weight enters the sum as its bitwise complement over the full result width, plus one at the least significant bit. The complement of the zero bits above the row acts as the sign-extension string. The subtract control flips the sign of every product row, which changes both the inversion pattern and the count of +1 corrections. A product of zero that is subtracted leaves Z unchanged.

Top module: `spp_macc`

## Requirements
- R1: With sub_i = 0, res_o one clock after the inputs are sampled equals Z + X*Y, with all three operands read as two's complement.
- R2: With sub_i = 1, res_o one clock after sampling equals Z - X*Y.
- R3: res_o (P_W+Q_W+1 bits, two's complement) is exact at the extremes: X and Y both at their minimum value, with Z at its minimum or maximum, in both add and subtract modes.
- R4: When X or Y is zero and sub_i = 1, res_o equals Z sign-extended; subtracting a zero product does not disturb the result.
- R5: The split form (SPLIT = 1, any XH_W < P_W, YH_W < Q_W) gives results identical to R1 and R2.
- R6: While rst_ni is low, res_o is zero, and it stays zero until the first clock edge after rst_ni rises.
- R7: res_o changes only on a rising clock edge; a change of inputs between edges does not appear at res_o before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | P_W | Multiplicand, two's complement |
| y_i | input | Q_W | Multiplier, two's complement |
| z_i | input | P_W+Q_W | Addend, two's complement |
| sub_i | input | 1 | 0: Z + X*Y, 1: Z - X*Y |
| res_o | output | P_W+Q_W+1 | Registered result, two's complement |

## Verification
The bench builds two 4x4 instances side by side, one in bit-level form and one split 2/3. All 256 operand pairs are swept in both modes against four addend values, including both range ends. This covers every sign combination, every zero product and the minimum-times-minimum case exhaustively. A wider 10x9 pair, one instance per form with the split at 6/5, takes random vectors plus the extreme corners. This exercises row weights and sign-extension strings that the small widths cannot separate.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int NUM_ROWS = 4;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
endpackage

// File: rtl/spp_rows_bit.sv
// Bit-level decomposition: core, sign corner, two negative-weight rows.
module spp_rows_bit #(
  parameter int P_W = 8,
  parameter int Q_W = 8,
  parameter int W   = P_W + Q_W + 1
) (
  input  logic [P_W-1:0]                      x_i,
  input  logic [Q_W-1:0]                      y_i,
  output logic [spp_pkg::NUM_ROWS-1:0][W-1:0] rows_o,
  output logic [spp_pkg::NUM_ROWS-1:0]        minus_o
);
  localparam int CW = P_W + Q_W - 2;

  logic          xs, ys;
  logic [P_W-2:0] xl;
  logic [Q_W-2:0] yl;
  logic [CW-1:0] core;

  assign xs = x_i[P_W-1];
  assign ys = y_i[Q_W-1];
  assign xl = x_i[P_W-2:0];
  assign yl = y_i[Q_W-2:0];
  assign core = CW'(xl) * CW'(yl);

  always_comb begin
    rows_o[0] = W'(core);
    rows_o[1] = W'(xs & ys) << (P_W + Q_W - 2);
    rows_o[2] = xs ? (W'(yl) << (P_W - 1)) : '0;
    rows_o[3] = ys ? (W'(xl) << (Q_W - 1)) : '0;
  end

  assign minus_o = 4'b1100;
endmodule

// File: rtl/spp_rows_split.sv
// Signed-high / unsigned-low decomposition into four sub-products.
module spp_rows_split #(
  parameter int P_W  = 8,
  parameter int Q_W  = 8,
  parameter int XH_W = 5,
  parameter int YH_W = 5,
  parameter int W    = P_W + Q_W + 1
) (
  input  logic [P_W-1:0]                      x_i,
  input  logic [Q_W-1:0]                      y_i,
  output logic [spp_pkg::NUM_ROWS-1:0][W-1:0] rows_o,
  output logic [spp_pkg::NUM_ROWS-1:0]        minus_o
);
  localparam int XL_W = P_W - XH_W;
  localparam int YL_W = Q_W - YH_W;

  logic [W-1:0] xh_e, xl_e, yh_e, yl_e;

  assign xh_e = {{(W-XH_W){x_i[P_W-1]}}, x_i[P_W-1 -: XH_W]};
  assign yh_e = {{(W-YH_W){y_i[Q_W-1]}}, y_i[Q_W-1 -: YH_W]};
  assign xl_e = {{(W-XL_W){1'b0}}, x_i[XL_W-1:0]};
  assign yl_e = {{(W-YL_W){1'b0}}, y_i[YL_W-1:0]};

  // modulo 2^W products of extended operands equal the signed products
  always_comb begin
    rows_o[0] = (xh_e * yh_e) << (XL_W + YL_W);
    rows_o[1] = (xh_e * yl_e) << XL_W;
    rows_o[2] = (xl_e * yh_e) << YL_W;
    rows_o[3] = xl_e * yl_e;
  end

  assign minus_o = '0;
endmodule

// File: rtl/spp_acc.sv
// Row summation: negated rows enter complemented, one LSB correction each.
module spp_acc #(
  parameter int W = 17,
  parameter int N = 4
) (
  input  logic [N-1:0][W-1:0] rows_i,
  input  logic [N-1:0]        neg_i,
  input  logic [W-1:0]        z_i,
  output logic [W-1:0]        sum_o
);
  logic [N-1:0][W-1:0] flip;

  for (genvar g = 0; g < N; g++) begin : g_flip
    assign flip[g] = rows_i[g] ^ {W{neg_i[g]}};
  end

  always_comb begin
    logic [W-1:0] acc;
    int           cnt;
    acc = z_i;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      acc = acc + flip[i];
      cnt = cnt + int'(neg_i[i]);
    end
    sum_o = acc + W'(cnt);
  end
endmodule

// File: rtl/spp_macc.sv
module spp_macc #(
  parameter int P_W   = 8,
  parameter int Q_W   = 8,
  parameter bit SPLIT = 1'b0,
  parameter int XH_W  = 5,
  parameter int YH_W  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [P_W-1:0]       x_i,
  input  logic [Q_W-1:0]       y_i,
  input  logic [P_W+Q_W-1:0]   z_i,
  input  logic                 sub_i,
  output logic [P_W+Q_W:0]     res_o
);
  import spp_pkg::*;

  localparam int Z_W = P_W + Q_W;
  localparam int W   = Z_W + 1;

  logic [NUM_ROWS-1:0][W-1:0] rows;
  logic [NUM_ROWS-1:0]        minus;
  logic [NUM_ROWS-1:0]        neg;
  logic [W-1:0]               z_ext;
  logic [W-1:0]               sum;
  op_e                        op;

  if (SPLIT) begin : g_split
    spp_rows_split #(.P_W(P_W), .Q_W(Q_W), .XH_W(XH_W), .YH_W(YH_W), .W(W)) u_rows (
      .x_i(x_i), .y_i(y_i), .rows_o(rows), .minus_o(minus)
    );
  end else begin : g_bit
    spp_rows_bit #(.P_W(P_W), .Q_W(Q_W), .W(W)) u_rows (
      .x_i(x_i), .y_i(y_i), .rows_o(rows), .minus_o(minus)
    );
  end

  assign op    = op_e'(sub_i);
  assign neg   = minus ^ {NUM_ROWS{op == OP_SUB}};
  assign z_ext = {z_i[Z_W-1], z_i};

  spp_acc #(.W(W), .N(NUM_ROWS)) u_acc (
    .rows_i(rows), .neg_i(neg), .z_i(z_ext), .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= sum;
  end
endmodule

// File: rtl/spp_macc_chk.sv
module spp_macc_chk #(
  parameter int P_W   = 8,
  parameter int Q_W   = 8,
  parameter bit SPLIT = 1'b0,
  parameter int XH_W  = 5,
  parameter int YH_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [P_W-1:0]     x_i,
  input logic [Q_W-1:0]     y_i,
  input logic [P_W+Q_W-1:0] z_i,
  input logic               sub_i,
  input logic [P_W+Q_W:0]   res_o
);
  localparam int W = P_W + Q_W + 1;

  logic [W-1:0] x_w, y_w, z_w, prod_w;
  logic         seen_q;

  assign x_w    = {{(W-P_W){x_i[P_W-1]}}, x_i};
  assign y_w    = {{(W-Q_W){y_i[Q_W-1]}}, y_i};
  assign z_w    = {z_i[P_W+Q_W-1], z_i};
  assign prod_w = x_w * y_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_add_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(sub_i) |-> res_o == $past(z_w + prod_w));

  a_r2_sub_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(sub_i) |-> res_o == $past(z_w - prod_w));

  a_r4_zero_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(sub_i && (x_i == '0 || y_i == '0)) |-> res_o == $past(z_w));

  a_r6_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> res_o == '0);
endmodule

bind spp_macc spp_macc_chk #(
  .P_W(P_W), .Q_W(Q_W), .SPLIT(SPLIT), .XH_W(XH_W), .YH_W(YH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i), .y_i(y_i),
  .z_i(z_i), .sub_i(sub_i), .res_o(res_o)
);

// File: tb/sim_spp_macc.sv
`timescale 1ns/1ps
module sim_spp_macc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic signed [3:0]  xs, ys;
  logic signed [7:0]  zs;
  logic               sub_s;
  logic signed [8:0]  r0, r1;
  logic signed [9:0]  xb;
  logic signed [8:0]  yb;
  logic signed [18:0] zb;
  logic               sub_b;
  logic signed [19:0] r2, r3;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  spp_macc #(.P_W(4), .Q_W(4), .SPLIT(1'b0), .XH_W(2), .YH_W(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xs), .y_i(ys), .z_i(zs), .sub_i(sub_s), .res_o(r0));
  spp_macc #(.P_W(4), .Q_W(4), .SPLIT(1'b1), .XH_W(2), .YH_W(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xs), .y_i(ys), .z_i(zs), .sub_i(sub_s), .res_o(r1));
  spp_macc #(.P_W(10), .Q_W(9), .SPLIT(1'b1), .XH_W(6), .YH_W(5)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xb), .y_i(yb), .z_i(zb), .sub_i(sub_b), .res_o(r2));
  spp_macc #(.P_W(10), .Q_W(9), .SPLIT(1'b0), .XH_W(6), .YH_W(5)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .x_i(xb), .y_i(yb), .z_i(zb), .sub_i(sub_b), .res_o(r3));

  task automatic chk(string req, longint got, longint exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint expect_v(longint z, longint x, longint y, bit s);
    return s ? z - x * y : z + x * y;
  endfunction

  task automatic run_small(int xv, int yv, int zv, bit s);
    longint e;
    @(negedge clk);
    xs = 4'(xv); ys = 4'(yv); zs = 8'(zv); sub_s = s;
    e = expect_v(zv, xv, yv, s);
    @(negedge clk);
    if (s && (xv == 0 || yv == 0)) chk("R4", longint'(r0), longint'(zv));
    else if (xv == -8 && yv == -8) chk("R3", longint'(r0), e);
    else chk(s ? "R2" : "R1", longint'(r0), e);
    chk("R5", longint'(r1), e);
  endtask

  task automatic run_big(longint xv, longint yv, longint zv, bit s, string req);
    longint e;
    @(negedge clk);
    xb = 10'(xv); yb = 9'(yv); zb = 19'(zv); sub_b = s;
    e = expect_v(zv, xv, yv, s);
    @(negedge clk);
    chk(req, longint'(r3), e);
    chk("R5", longint'(r2), e);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int zset [4] = '{-128, -1, 0, 127};
    longint e;
    xs = 4'sd5; ys = -4'sd3; zs = 8'sd9; sub_s = 1'b0;
    xb = '0; yb = '0; zb = '0; sub_b = 1'b0;
    repeat (3) @(negedge clk);
    // R6: cleared while reset held with nonzero inputs
    chk("R6", longint'(r0), 0);
    chk("R6", longint'(r1), 0);
    chk("R6", longint'(r2), 0);
    chk("R6", longint'(r3), 0);
    rst_n = 1'b1;
    chk("R6", longint'(r0), 0);

    for (int s = 0; s < 2; s++)
      for (int zi = 0; zi < 4; zi++)
        for (int xv = -8; xv < 8; xv++)
          for (int yv = -8; yv < 8; yv++)
            run_small(xv, yv, zset[zi], bit'(s));

    // R7: input change between edges is not visible before the next edge
    run_small(3, 7, 10, 1'b0);
    e = 31;
    xs = -4'sd8; ys = -4'sd8; zs = 8'sd127; sub_s = 1'b0;
    #5;
    chk("R7", longint'(r0), e);
    @(negedge clk);
    chk("R7", longint'(r0), 191);

    // R3: extremes on the wide instances
    run_big(-512, -256, 262143, 1'b0, "R3");
    run_big(-512, -256, -262144, 1'b1, "R3");
    run_big(-512, -256, -262144, 1'b0, "R3");
    run_big(-512, -256, 262143, 1'b1, "R3");
    run_big(511, -256, 262143, 1'b1, "R3");
    run_big(-512, 255, -262144, 1'b0, "R3");
    run_big(0, -256, 12345, 1'b1, "R4");
    run_big(-512, 0, -777, 1'b1, "R4");

    for (int i = 0; i < 3000; i++) begin
      longint xv, yv, zv;
      bit s;
      xv = longint'($urandom_range(0, 1023)) - 512;
      yv = longint'($urandom_range(0, 511)) - 256;
      zv = longint'($urandom_range(0, 524287)) - 262144;
      s  = bit'($urandom_range(0, 1));
      run_big(xv, yv, zv, s, s ? "R2" : "R1");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule